// File: doc/BRIEF.md
# Capture-Only Boundary-Scan Test Port for a Memory Device

This block is the test-access port logic for a memory device. A 16-state controller follows TMS on each rising edge of TCK. It shifts a 3-bit instruction between TDI and TDO, and a new instruction takes effect only when the controller passes through Update-IR. The active instruction then decides which data register is connected between TDI and TDO. There are three data registers: a one-bit bypass stage, a 32-bit identification word, and a boundary-scan register.

The boundary-scan register can only take a parallel snapshot of the device pins and shift it out. It never preloads a value and never drives a pin. An all-zero instruction samples the pins like the sample instruction, and it also raises the output-disable signal toward the pads. A dedicated high-impedance sample instruction does the same. TDO is driven only in the shift states and changes on the falling edge of TCK. The companion enable output tells the pad when to drive.

Top module: `mem_scan_tap`

## Requirements
- R1: In Capture-IR the instruction shift stage loads 001. During Shift-IR, TDO presents that stage least significant bit first, so the first three bits seen are 1, 0, 0.
- R2: A shifted instruction becomes active only in Update-IR. While Shift-IR is in progress, `pinHiZ` keeps the value it had before the scan.
- R3: While TRST is low, and whenever the controller is in Test-Logic-Reset, the identification instruction (001) becomes active, and `pinHiZ` and `tdoDrive` are 0.
- R4: With code 001 active, a data scan gives the 32-bit identification word least significant bit first, followed by the TDI bits delayed by 32 shifts.
- R5: With code 100 (sample) active, Capture-DR copies `pinSnap` into the boundary register. Shift-DR then gives `pinSnap[0]` first, and TDI appears after `BSR_LEN` shifts. `pinHiZ` stays 0.
- R6: Code 000 behaves as the sample instruction on the data path, and it drives `pinHiZ` to 1.
- R7: Code 010 connects the boundary register as in R5 and drives `pinHiZ` to 1.
- R8: Code 111 places a single-bit register in the path. It captures 0, so a scan gives 0 followed by TDI delayed by one shift.
- R9: The reserved codes 011, 101 and 110 act as bypass (R8) and leave `pinHiZ` at 0.
- R10: Passing through Update-DR changes neither the active instruction nor `pinHiZ`, and it leaves no preloaded value behind: the next capture again reflects the current `pinSnap`.
- R11: `tdoOut` and `tdoDrive` change only on the falling edge of TCK. `tdoDrive` is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R12: `pinHiZ` changes only as a result of Update-IR or Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tmsIn | input | 1 | Mode select, sampled on the rising edge |
| tdiIn | input | 1 | Serial data in, sampled on the rising edge |
| pinSnap | input | BSR_LEN | Device pin values offered for parallel capture |
| tdoOut | output | 1 | Serial data out, updated on the falling edge |
| tdoDrive | output | 1 | High when the pad should drive `tdoOut`; otherwise high impedance |
| pinHiZ | output | 1 | Forces the device outputs to high impedance |

## Verification
The snapshot assertion assumes that `pinSnap` is stable around the rising edge that leaves Capture-DR. The bench keeps to this by changing the pins only at a falling edge while the controller idles in Run-Test/Idle, well before any capture. The assertions also assume that TRST is released only between edges, so the controller starts cleanly from Test-Logic-Reset. All TMS and TDI changes are applied half a period before the rising edge that samples them.

// File: rtl/mem_scan_pkg.sv
package mem_scan_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHF_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHF_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tapState_t;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } drPath_t;

  typedef struct packed {
    logic    captureDr;
    logic    shiftDr;
    logic    updateDr;
    logic    shiftIr;
    drPath_t path;
  } scanStrobe_t;

endpackage

// File: rtl/mem_scan_ctrl.sv
module mem_scan_ctrl
  import mem_scan_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tmsIn,
  input  logic        tdiIn,
  output scanStrobe_t strobe,
  output logic        irTdo,
  output logic        pinHiZ
);

  tapState_t tapState, tapNext;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] activeIr;

  // Controller next-state function
  always_comb begin
    tapNext = tapState;
    unique case (tapState)
      TAP_RESET:  tapNext = tmsIn ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   tapNext = tmsIn ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: tapNext = tmsIn ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: tapNext = tmsIn ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_SHF_DR: tapNext = tmsIn ? TAP_EX1_DR : TAP_SHF_DR;
      TAP_EX1_DR: tapNext = tmsIn ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: tapNext = tmsIn ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: tapNext = tmsIn ? TAP_UPD_DR : TAP_SHF_DR;
      TAP_UPD_DR: tapNext = tmsIn ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: tapNext = tmsIn ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: tapNext = tmsIn ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_SHF_IR: tapNext = tmsIn ? TAP_EX1_IR : TAP_SHF_IR;
      TAP_EX1_IR: tapNext = tmsIn ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: tapNext = tmsIn ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: tapNext = tmsIn ? TAP_UPD_IR : TAP_SHF_IR;
      TAP_UPD_IR: tapNext = tmsIn ? TAP_SEL_DR : TAP_IDLE;
      default:    tapNext = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TAP_RESET;
    else        tapState <= tapNext;
  end

  // Instruction shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                      irShift <= IR_CAPTURE;
    else if (tapState == TAP_CAP_IR) irShift <= IR_CAPTURE;
    else if (tapState == TAP_SHF_IR) irShift <= {tdiIn, irShift[IR_W-1:1]};
  end

  // Active instruction: changes only at update or test-logic reset
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                      activeIr <= OP_IDCODE;
    else if (tapState == TAP_RESET)  activeIr <= OP_IDCODE;
    else if (tapState == TAP_UPD_IR) activeIr <= irShift;
  end

  // Instruction decode
  drPath_t pathSel;
  logic    hizSel;
  always_comb begin
    unique case (activeIr)
      OP_EXTEST:  begin pathSel = PATH_BSR; hizSel = 1'b1; end
      OP_IDCODE:  begin pathSel = PATH_ID;  hizSel = 1'b0; end
      OP_SAMPLEZ: begin pathSel = PATH_BSR; hizSel = 1'b1; end
      OP_SAMPLE:  begin pathSel = PATH_BSR; hizSel = 1'b0; end
      default:    begin pathSel = PATH_BYP; hizSel = 1'b0; end
    endcase
  end

  assign strobe.captureDr = (tapState == TAP_CAP_DR);
  assign strobe.shiftDr   = (tapState == TAP_SHF_DR);
  assign strobe.updateDr  = (tapState == TAP_UPD_DR);
  assign strobe.shiftIr   = (tapState == TAP_SHF_IR);
  assign strobe.path      = pathSel;
  assign irTdo            = irShift[0];
  assign pinHiZ           = hizSel;

  // R3: test-logic reset always restores the identification instruction
  assert_reset_idcode_R3: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_RESET) |=> (activeIr == OP_IDCODE));

  // R2: instruction holds outside update and reset
  assert_ir_hold_R2: assert property (@(posedge tck) disable iff (!trstN)
    (tapState != TAP_UPD_IR && tapState != TAP_RESET) |=> $stable(activeIr));

  // R12: output disable moves only after update-IR or reset
  assert_hiz_source_R12: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(pinHiZ) |-> ($past(tapState) == TAP_UPD_IR || $past(tapState) == TAP_RESET));

  // R1: capture-IR leaves the fixed pattern in the shift stage
  assert_ir_capture_R1: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_CAP_IR) |=> (irShift == IR_CAPTURE));

endmodule

// File: rtl/mem_scan_dp.sv
module mem_scan_dp
  import mem_scan_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A5C_E0F3,
  parameter int              BSR_LEN = 16
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdiIn,
  input  scanStrobe_t        strobe,
  input  logic               irTdo,
  input  logic [BSR_LEN-1:0] pinSnap,
  output logic               tdoOut,
  output logic               tdoDrive
);

  logic               bypReg;
  logic [ID_W-1:0]    idReg;
  logic [BSR_LEN-1:0] bsrReg;
  logic               drTdo;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypReg <= 1'b0;
    else if (strobe.path == PATH_BYP) begin
      if (strobe.captureDr)    bypReg <= 1'b0;
      else if (strobe.shiftDr) bypReg <= tdiIn;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idReg <= '0;
    else if (strobe.path == PATH_ID) begin
      if (strobe.captureDr)    idReg <= ID_CODE;
      else if (strobe.shiftDr) idReg <= {tdiIn, idReg[ID_W-1:1]};
    end
  end

  // Boundary register: capture and shift only, no update stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bsrReg <= '0;
    else if (strobe.path == PATH_BSR) begin
      if (strobe.captureDr)    bsrReg <= pinSnap;
      else if (strobe.shiftDr) bsrReg <= {tdiIn, bsrReg[BSR_LEN-1:1]};
    end
  end

  always_comb begin
    unique case (strobe.path)
      PATH_ID:  drTdo = idReg[0];
      PATH_BSR: drTdo = bsrReg[0];
      default:  drTdo = bypReg;
    endcase
  end

  // Serial output retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoOut   <= 1'b0;
      tdoDrive <= 1'b0;
    end else begin
      tdoOut   <= strobe.shiftIr ? irTdo : drTdo;
      tdoDrive <= strobe.shiftIr | strobe.shiftDr;
    end
  end

  // R8: bypass stage captures zero
  assert_bypass_zero_R8: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.captureDr && strobe.path == PATH_BYP) |=> (bypReg == 1'b0));

  // R5: snapshot equals the pins seen at the capture edge
  assert_bsr_snapshot_R5: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.captureDr && strobe.path == PATH_BSR) |=> (bsrReg == $past(pinSnap)));

  // R10: update-DR leaves the boundary register untouched
  assert_no_preload_R10: assert property (@(posedge tck) disable iff (!trstN)
    strobe.updateDr |=> $stable(bsrReg));

  // R11: drive enable seen at a rising edge matches the current shift state
  assert_tdo_drive_R11: assert property (@(posedge tck) disable iff (!trstN)
    tdoDrive == (strobe.shiftIr | strobe.shiftDr));

endmodule

// File: rtl/mem_scan_tap.sv
module mem_scan_tap
  import mem_scan_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h1A5C_E0F3,
  parameter int          BSR_LEN = 16
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tmsIn,
  input  logic               tdiIn,
  input  logic [BSR_LEN-1:0] pinSnap,
  output logic               tdoOut,
  output logic               tdoDrive,
  output logic               pinHiZ
);

  scanStrobe_t strobe;
  logic        irTdo;

  mem_scan_ctrl ctrl_i (
    .tck    (tck),
    .trstN  (trstN),
    .tmsIn  (tmsIn),
    .tdiIn  (tdiIn),
    .strobe (strobe),
    .irTdo  (irTdo),
    .pinHiZ (pinHiZ)
  );

  mem_scan_dp #(
    .ID_CODE (ID_CODE),
    .BSR_LEN (BSR_LEN)
  ) dp_i (
    .tck      (tck),
    .trstN    (trstN),
    .tdiIn    (tdiIn),
    .strobe   (strobe),
    .irTdo    (irTdo),
    .pinSnap  (pinSnap),
    .tdoOut   (tdoOut),
    .tdoDrive (tdoDrive)
  );

endmodule

// File: tb/mem_scan_tap_tb_top.sv
`timescale 1ns/1ps
module mem_scan_tap_tb_top;

  localparam int          BSR_LEN  = 16;
  localparam logic [31:0] ID_VAL   = 32'h1A5C_E0F3;
  localparam int          SCAN_LEN = 40;

  // {code[2:0], expected pinHiZ, kind[1:0]} ; kind 0 bypass, 1 id, 2 boundary
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 1'b1, 2'd2}, {3'b001, 1'b0, 2'd1}, {3'b010, 1'b1, 2'd2}, {3'b011, 1'b0, 2'd0},
    {3'b100, 1'b0, 2'd2}, {3'b101, 1'b0, 2'd0}, {3'b110, 1'b0, 2'd0}, {3'b111, 1'b0, 2'd0}
  };

  logic tck = 1'b0;
  always #2.5 tck = ~tck;

  logic               trstN = 1'b0;
  logic               tmsIn = 1'b1;
  logic               tdiIn = 1'b0;
  logic [BSR_LEN-1:0] pinSnap = '0;
  logic               tdoOut, tdoDrive, pinHiZ;

  mem_scan_tap #(.ID_CODE(ID_VAL), .BSR_LEN(BSR_LEN)) dut_i (
    .tck(tck), .trstN(trstN), .tmsIn(tmsIn), .tdiIn(tdiIn), .pinSnap(pinSnap),
    .tdoOut(tdoOut), .tdoDrive(tdoDrive), .pinHiZ(pinHiZ)
  );

  int   nChecks = 0;
  int   nFails  = 0;
  logic smpTdo, smpDrv;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tms, input logic tdi);
    @(negedge tck);
    tmsIn = tms;
    tdiIn = tdi;
    #1;
    smpTdo = tdoOut;
    smpDrv = tdoDrive;
  endtask

  task automatic goReset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [2:0] code, output logic [2:0] capSeen,
                        output logic hizMid, output logic drvAll);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    drvAll = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      capSeen[i] = smpTdo;
      drvAll &= smpDrv;
      if (i == 1) hizMid = pinHiZ;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic scanDr(input logic [SCAN_LEN-1:0] din, output logic [SCAN_LEN-1:0] dout,
                        output logic drvAll);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    drvAll = 1'b1;
    for (int i = 0; i < SCAN_LEN; i++) begin
      step(i == SCAN_LEN - 1, din[i]);
      dout[i] = smpTdo;
      drvAll &= smpDrv;
    end
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  function automatic logic [SCAN_LEN-1:0] expScan(input logic [1:0] kind,
      input logic [BSR_LEN-1:0] pins, input logic [SCAN_LEN-1:0] din);
    int len;
    logic [63:0] cap;
    len = (kind == 2'd1) ? 32 : (kind == 2'd2) ? BSR_LEN : 1;
    cap = (kind == 2'd1) ? {32'h0, ID_VAL} : (kind == 2'd2) ? {{(64-BSR_LEN){1'b0}}, pins} : 64'h0;
    for (int i = 0; i < SCAN_LEN; i++)
      expScan[i] = (i < len) ? cap[i] : din[i - len];
  endfunction

  function automatic string reqOf(input logic [2:0] code);
    case (code)
      3'b000:  return "R6";
      3'b001:  return "R4";
      3'b010:  return "R7";
      3'b100:  return "R5";
      3'b111:  return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge tck);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [2:0]          cap;
    logic                hizMid, drv, prevHiz;
    logic [SCAN_LEN-1:0] din, dout;
    logic [BSR_LEN-1:0]  p2;

    // R3: state held while TRST is low
    #7;
    check("R3 reset drive", tdoDrive, 0);
    check("R3 reset hiz", pinHiZ, 0);
    @(negedge tck); trstN = 1'b1;
    goReset();
    check("R11 idle drive", smpDrv, 0);
    din = 40'hC3_5A5A_0F0F;
    scanDr(din, dout, drv);
    check("R3 R4 idcode after reset", dout, expScan(2'd1, pinSnap, din));

    // Table of instructions
    prevHiz = pinHiZ;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code;
      code = VEC[v][5:3];
      @(negedge tck);
      pinSnap = 16'hA5C3 ^ (16'(v) * 16'h1357);
      loadIr(code, cap, hizMid, drv);
      check("R1 ir capture", cap, 3'b001);
      check("R11 ir drive", drv, 1);
      check("R2 hiz held mid shift", hizMid, prevHiz);
      step(1'b0, 1'b0);
      check({reqOf(code), " R12 hiz after update"}, pinHiZ, VEC[v][2]);
      din = {8'(v), 32'h9E37_79B9 ^ 32'(v)};
      scanDr(din, dout, drv);
      check({reqOf(code), " scan"}, dout, expScan(VEC[v][1:0], pinSnap, din));
      check("R11 dr drive", drv, 1);
      check("R10 hiz after update-dr", pinHiZ, VEC[v][2]);
      prevHiz = pinHiZ;
    end

    // R12 R3: TMS-only reset clears output disable and restores IDCODE
    loadIr(3'b000, cap, hizMid, drv);
    step(1'b0, 1'b0);
    check("R6 extest hiz", pinHiZ, 1);
    goReset();
    check("R12 R3 hiz cleared by tms reset", pinHiZ, 0);
    din = 40'h11_2233_4455;
    scanDr(din, dout, drv);
    check("R3 idcode after tms reset", dout, expScan(2'd1, pinSnap, din));

    // R10: no preload, next capture follows new pins
    loadIr(3'b100, cap, hizMid, drv);
    din = 40'hFF_FFFF_FFFF;
    scanDr(din, dout, drv);
    check("R10 first sample", dout, expScan(2'd2, pinSnap, din));
    p2 = 16'h0FF0;
    @(negedge tck); pinSnap = p2;
    din = 40'h00_0000_0000;
    scanDr(din, dout, drv);
    check("R10 second sample not preloaded", dout, expScan(2'd2, p2, din));
    check("R10 hiz unchanged", pinHiZ, 0);

    // R11: TDO holds across the rising edge, changes at the falling edge
    goReset();
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R11 first id bit", smpTdo, ID_VAL[0]);
    @(posedge tck); #1;
    check("R11 tdo stable at rising edge", tdoOut, ID_VAL[0]);
    step(1'b0, 1'b0);
    check("R11 second id bit", smpTdo, ID_VAL[1]);
    goReset();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule